// File: doc/BRIEF.md
# Jitter-Gated Counter Random Harvester

This block converts a randomly timed gate into random bits. An external pulse generator raises `win_req` for a fixed excitation window. Partway through each window, after a random delay set by a volatile switching element, an analog comparator raises `cmp_async`. The comparator drops when the window ends. While the synchronized comparator level is high and the window is open, a free-running fast clock advances a counter. Because the delay is random, the number of clock edges inside the gate is random. The fast-toggling low bits of that count are the entropy.

Some time after each window closes, the block latches a configurable number of low-order counter bits into `out_word` and pulses `out_valid`. The counter is not cleared between windows, so every result depends on the whole history since reset. Two health flags mark windows that produced no usable entropy. One marks a window in which the gate never opened. The other marks a window in which the gate was already high when the window began, which shows that the switching element had not relaxed.

Top module: `jitter_harvester`

## Requirements
- R1: The 16-bit counter increments by one on a clock edge only when the synchronized comparator level is high and `win_req` is high at that edge. A comparator level that is high while `win_req` is low leaves the count unchanged.
- R2: `cmp_async` passes through a two-register synchronizer before it can enable counting. A level first sampled at edge k can first count at edge k+2.
- R3: Let E be the first edge at which `win_req` is sampled low after being high. At edge E+2 the result is latched, and `out_valid` is high for exactly the one cycle that follows E+2.
- R4: `out_word` bit i holds counter bit i for i < N and is 0 otherwise, where N is `bits_cfg` limited to the range 1..8. A value of 0 selects 1 bit, and any value above 8 selects 8 bits.
- R5: `err_no_switch` is high for one cycle at the latch point of a window in which the counter never incremented.
- R6: `err_stuck_on` is high for one cycle at the latch point of a window whose first edge with `win_req` high saw the synchronized comparator level already high.
- R7: For any window that raises either health flag, `out_valid` stays low and `out_word` keeps its previous value.
- R8: The counter and all outputs are cleared only by the synchronous active-low reset. After reset, `out_word` and all strobes read 0. Between windows the count carries over, so each word reflects the accumulated count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_req | input | 1 | Excitation window request, synchronous to clk |
| cmp_async | input | 1 | Comparator level, asynchronous |
| bits_cfg | input | 4 | Number of harvested bits (limited to 1..8) |
| out_word | output | 8 | Harvested random word, upper bits zero |
| out_valid | output | 1 | One-cycle strobe for a good window |
| err_no_switch | output | 1 | One-cycle flag: gate never opened |
| err_stuck_on | output | 1 | One-cycle flag: gate already high at window start |

## Verification
The hardest situation to reach is a stuck-on window. It needs the comparator to be high for at least two edges before the window request rises, so that the synchronized level is already high at the start edge. The stimulus raises `cmp_async` several cycles ahead of a window and keeps it high through the window. In a separate case, the comparator is held high with no window open, to show that such a level does not advance the count. Random windows with random delays, lengths and bit counts, including out-of-range settings, run alongside a bench model of the gated counter. This model follows the accumulated count across windows and across a mid-run reset.

// File: rtl/harv_pkg.sv
// Shared helpers for the jitter-gated harvester.
// Assumes: the harvested bit count is requested as an unsigned field.
package harv_pkg;

    // Limit a requested bit count to 1..maxb.
    function automatic int harv_clamp(input int req, input int maxb);
        if (req < 1)    return 1;
        if (req > maxb) return maxb;
        return req;
    endfunction

endpackage

// File: rtl/sync_chain.sv
// Multi-register synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the output is only a level, never an edge count.
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gate_counter.sv
// Free-running counter that advances only while gate and window are both open.
// Assumes: only the global reset clears it; the count persists across windows.
module gate_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             open,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    // Count gated fast-clock edges; wraps modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (gate && open) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && open) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate && open) |=> $stable(cnt_q));
endmodule

// File: rtl/window_ctrl.sv
// Window tracking, health checks and result latching.
// Assumes: win_req is synchronous to clk; windows are separated by at least
// SETTLE+2 idle cycles so a new window never starts during the settle delay.
module window_ctrl
    import harv_pkg::*;
#(
    parameter int OUT_W  = 8,
    parameter int CFG_W  = 4,
    parameter int SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_req,
    input  logic             gate,
    input  logic [OUT_W-1:0] cnt_low,
    input  logic [CFG_W-1:0] bits_cfg,
    output logic [OUT_W-1:0] out_word,
    output logic             out_valid,
    output logic             err_no_switch,
    output logic             err_stuck_on
);
    localparam int SW = $clog2(SETTLE + 1);

    logic          win_d;
    logic          saw_inc;
    logic          stuck;
    logic [SW-1:0] settle;
    logic [OUT_W-1:0] keep_mask;
    int            n_bits;

    // Resolve the requested bit count into a low-order mask.
    always_comb n_bits = harv_clamp(int'(bits_cfg), OUT_W);

    for (genvar i = 0; i < OUT_W; i++) begin : g_mask
        assign keep_mask[i] = (i < n_bits);
    end

    // Track window edges, gather health and latch the result after settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_d         <= 1'b0;
            saw_inc       <= 1'b0;
            stuck         <= 1'b0;
            settle        <= '0;
            out_word      <= '0;
            out_valid     <= 1'b0;
            err_no_switch <= 1'b0;
            err_stuck_on  <= 1'b0;
        end else begin
            win_d         <= win_req;
            out_valid     <= 1'b0;
            err_no_switch <= 1'b0;
            err_stuck_on  <= 1'b0;
            if (win_req && !win_d) begin
                stuck   <= gate;
                saw_inc <= gate;
            end else if (win_req && gate) begin
                saw_inc <= 1'b1;
            end
            if (!win_req && win_d) begin
                settle <= SW'(SETTLE);
            end else if (settle != '0) begin
                settle <= settle - 1'b1;
                if (settle == SW'(1)) begin
                    err_no_switch <= !saw_inc;
                    err_stuck_on  <= stuck;
                    if (saw_inc && !stuck) begin
                        out_valid <= 1'b1;
                        out_word  <= cnt_low & keep_mask;
                    end
                end
            end
        end
    end

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    p_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(win_req));
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!err_no_switch && !err_stuck_on));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_no_switch || err_stuck_on) |-> $stable(out_word));
    p_flag_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_switch |=> !err_no_switch);
endmodule

// File: rtl/jitter_harvester.sv
// Top: synchronizes the comparator, counts gated clock edges and harvests
// the low-order bits of the count once per excitation window.
// Assumes: win_req is synchronous to clk; cmp_async may change at any time.
module jitter_harvester #(
    parameter int CNT_W       = 16,
    parameter int OUT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE      = 2,
    parameter int CFG_W       = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_req,
    input  logic             cmp_async,
    input  logic [CFG_W-1:0] bits_cfg,
    output logic [OUT_W-1:0] out_word,
    output logic             out_valid,
    output logic             err_no_switch,
    output logic             err_stuck_on
);
    logic             gate;
    logic [CNT_W-1:0] cnt;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_async), .q_sync(gate)
    );

    gate_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .gate(gate), .open(win_req), .cnt(cnt)
    );

    window_ctrl #(.OUT_W(OUT_W), .CFG_W(CFG_W), .SETTLE(SETTLE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .win_req(win_req), .gate(gate),
        .cnt_low(cnt[OUT_W-1:0]), .bits_cfg(bits_cfg),
        .out_word(out_word), .out_valid(out_valid),
        .err_no_switch(err_no_switch), .err_stuck_on(err_stuck_on)
    );

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (out_word == '0 && !out_valid));
endmodule

// File: tb/tb_jitter_harvester.sv
module tb_jitter_harvester;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_req = 1'b0;
    logic       cmp_async = 1'b0;
    logic [3:0] bits_cfg = 4'd6;
    logic [7:0] out_word;
    logic       out_valid, err_no_switch, err_stuck_on;

    int checks = 0;
    int errors = 0;
    logic [7:0] prev_word = 8'd0;

    // Bench model of the requirements (R1, R2, R6, R8).
    logic        m_s1 = 0, m_s2 = 0, m_wd = 0, m_inc = 0, m_stuck = 0;
    logic [15:0] m_cnt = 0;

    jitter_harvester dut (
        .clk(clk), .rst_n(rst_n), .win_req(win_req), .cmp_async(cmp_async),
        .bits_cfg(bits_cfg), .out_word(out_word), .out_valid(out_valid),
        .err_no_switch(err_no_switch), .err_stuck_on(err_stuck_on)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_wd <= 0; m_cnt <= 0; m_inc <= 0; m_stuck <= 0;
        end else begin
            m_s1 <= cmp_async;
            m_s2 <= m_s1;
            m_wd <= win_req;
            if (m_s2 && win_req) m_cnt <= m_cnt + 1'b1;
            if (win_req && !m_wd) begin
                m_stuck <= m_s2; m_inc <= m_s2;
            end else if (win_req && m_s2) m_inc <= 1'b1;
        end
    end

    function automatic logic [7:0] exp_mask(input int cfg);
        int n = (cfg < 1) ? 1 : ((cfg > 8) ? 8 : cfg);
        return 8'((16'd1 << n) - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One window: length len, comparator rises dly cycles in, optionally kept high.
    task automatic window(input int len, input int dly, input logic keep_high, input logic [3:0] cfg, input string req);
        logic [7:0] exp_w;
        logic       exp_v;
        @(negedge clk);
        bits_cfg = cfg;
        win_req = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (i == dly) cmp_async = 1'b1;
            @(negedge clk);
        end
        win_req = 1'b0;
        if (!keep_high) cmp_async = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        exp_v = m_inc && !m_stuck;
        exp_w = exp_v ? (m_cnt[7:0] & exp_mask(int'(cfg))) : prev_word;
        chk(req, 32'(out_valid), 32'(exp_v), "out_valid at latch (R3)");
        chk(req, 32'(out_word), 32'(exp_w), "out_word (R4/R7)");
        chk("R5", 32'(err_no_switch), 32'(!m_inc), "err_no_switch");
        chk("R6", 32'(err_stuck_on), 32'(m_stuck), "err_stuck_on");
        prev_word = out_word;
        @(negedge clk);
        chk("R3", 32'(out_valid), 32'd0, "out_valid single pulse");
        cmp_async = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8", 32'(out_word), 32'd0, "reset out_word");
        chk("R8", 32'(out_valid | err_no_switch | err_stuck_on), 32'd0, "reset strobes");

        // R2/R4: directed delay, default 6 bits; count = 30-5-2 = 23
        window(30, 5, 1'b0, 4'd6, "R2");
        chk("R2", 32'(out_word), 32'd23, "sync latency count");
        // R4: out-of-range settings
        window(41, 3, 1'b0, 4'd0, "R4");
        window(57, 2, 1'b0, 4'd12, "R4");
        window(44, 9, 1'b0, 4'd3, "R4");
        // R5: gate never opens
        window(25, 25, 1'b0, 4'd8, "R7");
        // R1: comparator high with no window open must not count
        @(negedge clk); cmp_async = 1'b1;
        repeat (12) @(negedge clk);
        cmp_async = 1'b0;
        repeat (4) @(negedge clk);
        window(20, 4, 1'b0, 4'd8, "R1");
        // R6: gate already high at window start
        @(negedge clk); cmp_async = 1'b1;
        repeat (4) @(negedge clk);
        window(20, 0, 1'b1, 4'd8, "R7");
        // Late rise: synchronized gate arrives after window end -> no switch
        window(20, 19, 1'b0, 4'd8, "R5");
        // R8: reset mid-run clears the accumulated count
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        prev_word = 8'd0;
        window(15, 2, 1'b0, 4'd8, "R8");
        chk("R8", 32'(out_word), 32'd11, "count restarts after reset");
        // Random windows (R1, R3, R4)
        for (int k = 0; k < 60; k++) begin
            int len = 10 + int'($urandom % 90);
            int dly = int'($urandom % (len + 2));
            window(len, dly, 1'b0, 4'($urandom % 16), "R4");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule